// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial input into characters and queues them for a host. It watches the line on a 16x sample enable that the caller supplies. It waits for a falling edge and confirms the start bit at the middle of the bit. It then collects 5 to 8 data bits, least significant bit first. An optional parity bit follows, and the stop bit is checked last. Every character goes into a 64-entry queue. Each entry holds the data byte together with three flags: parity error, framing error and break.

The register and interrupt logic outside this block reads the head of the queue. It also uses the fill level, a trigger-level indication, an overrun pulse and a character-timeout indication. The bit-rate divider and the bus decoding live elsewhere. The character length and parity mode arrive as static inputs.

Top module: `serial_rx_buf`

## Requirements
- R1: After reset, `empty_o` is 1, `level_o` is 0, and `thresh_o`, `overrun_o` and `timeout_o` are all 0.
- R2: The `len_sel_i` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits arrive least significant first. A stored byte is right-aligned, with the unused upper bits set to 0.
- R3: When `par_en_i` is 1, one parity bit follows the data. With `par_odd_i`=0, the data bits plus the parity bit must hold an even number of ones. With `par_odd_i`=1, they must hold an odd number. A mismatch sets the entry's `rd_perr_o` flag, and the data is still stored.
- R4: A stop bit sampled low sets the entry's `rd_ferr_o` flag when the frame is not a break. The data is still stored.
- R5: A low pulse that ends before the middle of the start bit (the 8th sample tick) stores nothing.
- R6: A break is a line held low through all data, parity and stop positions. It stores exactly one entry: data 0x00, break flag 1, and parity and framing flags 0. No further entry is stored until the line has returned high.
- R7: The queue holds 64 entries in arrival order. The head entry is shown on the read outputs while `empty_o` is 0. A one-cycle `rd_i` pulse removes the head entry.
- R8: A character that completes while the queue holds 64 entries is discarded. The stored entries and the level stay unchanged, and `overrun_o` pulses high for one cycle.
- R9: `thresh_o` is 1 exactly when `trig_lvl_i` is non-zero and `level_o` is at least `trig_lvl_i`.
- R10: `timeout_o` rises when the queue is non-empty and no character has been stored and no read has been made for 4 character times. A character time is 16 ticks times the frame length in bits, counting start, data, parity and one stop bit. A store or a read clears `timeout_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Sample enable at 16 times the bit rate |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| len_sel_i | input | 2 | Data length code (0..3 gives 5..8 bits) |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| trig_lvl_i | input | 7 | Trigger level for `thresh_o` (0 disables it) |
| rd_i | input | 1 | Remove the head entry |
| rd_data_o | output | 8 | Head entry data |
| rd_perr_o | output | 1 | Head entry parity error flag |
| rd_ferr_o | output | 1 | Head entry framing error flag |
| rd_brk_o | output | 1 | Head entry break flag |
| empty_o | output | 1 | Queue empty |
| level_o | output | 7 | Number of stored entries |
| thresh_o | output | 1 | Level has reached the trigger level |
| overrun_o | output | 1 | One-cycle pulse: a character was dropped on a full queue |
| timeout_o | output | 1 | Non-empty queue has been idle for 4 character times |

## Verification
The input passes through two synchronizer flops. A character is therefore stored one clock after the tick that samples its stop bit, and up to about three clocks later than the line edge suggests. The bench never samples inside that window. The monitor waits for `empty_o` to fall and compares the head entry before it pulses `rd_i`, so the check does not depend on the exact store cycle. Level, threshold and overrun are read at least half a bit time after the last frame has ended. The timeout is due 2560 clocks after the store in the 8-bit, no-parity format. It is sampled once at about 1600 clocks, where it must still be 0, and once at about 3100 clocks, where it must be 1. This keeps both samples well away from the edge.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_item_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKW
  } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[g] <= 1'b1;
        else if (g == 0) sh_q[g] <= d_i;
        else sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rxd_i,
  input  logic [1:0] len_i,
  input  logic     par_en_i,
  input  logic     par_odd_i,
  output logic     push_o,
  output rx_item_t item_o
);
  rx_state_e  state_q;
  logic [3:0] cnt_q;
  logic [2:0] bidx_q;
  logic [7:0] shreg_q;
  logic       pbit_q;
  logic       zero_q;
  logic [2:0] last_bit;
  logic [7:0] aligned;
  logic       perr_c;
  logic       brk_c;
  logic       mid;

  assign last_bit = {1'b0, len_i} + 3'd4;
  assign aligned  = shreg_q >> (2'd3 - len_i);
  assign perr_c   = par_en_i & (pbit_q ^ (^aligned) ^ par_odd_i);
  assign brk_c    = zero_q & ~rxd_i;
  assign mid      = (cnt_q == 4'd15);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      pbit_q  <= 1'b0;
      zero_q  <= 1'b0;
      push_o  <= 1'b0;
      item_o  <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        case (state_q)
          S_IDLE: begin
            cnt_q <= '0;
            if (!rxd_i) state_q <= S_START;
          end
          S_START: begin
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              if (rxd_i) state_q <= S_IDLE;  // false start
              else begin
                state_q <= S_DATA;
                cnt_q   <= '0;
                bidx_q  <= '0;
                zero_q  <= 1'b1;
              end
            end
          end
          S_DATA: begin
            cnt_q <= cnt_q + 4'd1;
            if (mid) begin
              shreg_q <= {rxd_i, shreg_q[7:1]};
              zero_q  <= zero_q & ~rxd_i;
              bidx_q  <= bidx_q + 3'd1;
              if (bidx_q == last_bit) state_q <= par_en_i ? S_PAR : S_STOP;
            end
          end
          S_PAR: begin
            cnt_q <= cnt_q + 4'd1;
            if (mid) begin
              pbit_q  <= rxd_i;
              zero_q  <= zero_q & ~rxd_i;
              state_q <= S_STOP;
            end
          end
          S_STOP: begin
            cnt_q <= cnt_q + 4'd1;
            if (mid) begin
              push_o      <= 1'b1;
              item_o.brk  <= brk_c;
              item_o.data <= brk_c ? 8'h00 : aligned;
              item_o.perr <= brk_c ? 1'b0 : perr_c;
              item_o.ferr <= ~rxd_i & ~brk_c;
              state_q     <= brk_c ? S_BRKW : S_IDLE;
            end
          end
          S_BRKW: if (rxd_i) state_q <= S_IDLE;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  p_push_from_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(state_q) == S_STOP);
  p_break_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && item_o.brk) |-> (item_o.data == 8'h00 && !item_o.perr && !item_o.ferr));
  p_brk_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BRKW) |-> !push_o || item_o.brk);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          overrun_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;
  logic          do_wr, do_rd;

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LW'(DEPTH));
  assign do_wr   = push_i & ~full_o;
  assign do_rd   = pop_i & ~empty_o;
  assign rdata_o = mem_q[rptr_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      level_q   <= '0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= push_i & full_o;
      if (do_wr) wptr_q <= wptr_q + AW'(1);
      if (do_rd) rptr_q <= rptr_q + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   level_q <= level_q + LW'(1);
        2'b01:   level_q <= level_q - LW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  p_level_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));
  p_full_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(level_q) && $stable(wptr_q));
  p_overrun_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(full_o));
endmodule

// File: rtl/srx_timeout.sv
module srx_timeout #(
  parameter int TO_CHARS = 4,
  parameter int CW       = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       empty_i,
  input  logic       push_i,
  input  logic       pop_i,
  output logic       timeout_o
);
  logic [3:0]    frame_bits;
  logic [CW-1:0] limit;
  logic [CW-1:0] cnt_q;

  // start + data + optional parity + one stop
  assign frame_bits = 4'({2'b0, len_i}) + 4'd7 + 4'({3'b0, par_en_i});
  assign limit      = CW'(TO_CHARS * 16) * CW'(frame_bits);
  assign timeout_o  = ~empty_i & (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (empty_i || push_i || pop_i) cnt_q <= '0;
    else if (tick_i && cnt_q < limit) cnt_q <= cnt_q + CW'(1);
  end

  p_to_needs_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !empty_i);
  p_to_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i || pop_i) |=> !timeout_o);
endmodule

// File: rtl/serial_rx_buf.sv
module serial_rx_buf
  import srx_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int SYNC     = 2,
  parameter int TO_CHARS = 4,
  localparam int LW      = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic          rxd_i,
  input  logic [1:0]    len_sel_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic [LW-1:0] trig_lvl_i,
  input  logic          rd_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_perr_o,
  output logic          rd_ferr_o,
  output logic          rd_brk_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o,
  output logic          thresh_o,
  output logic          overrun_o,
  output logic          timeout_o
);
  localparam int IW = $bits(rx_item_t);

  logic     rxd_s;
  logic     push;
  rx_item_t item, head;
  logic     full;

  srx_sync #(.STAGES(SYNC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
  );

  srx_sampler u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick16_i), .rxd_i(rxd_s),
    .len_i(len_sel_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .push_o(push), .item_o(item)
  );

  srx_fifo #(.DEPTH(DEPTH), .W(IW)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .wdata_i(item),
    .pop_i(rd_i), .rdata_o(head), .level_o(level_o), .empty_o(empty_o),
    .full_o(full), .overrun_o(overrun_o)
  );

  srx_timeout #(.TO_CHARS(TO_CHARS)) u_to (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick16_i), .len_i(len_sel_i),
    .par_en_i(par_en_i), .empty_i(empty_o), .push_i(push), .pop_i(rd_i),
    .timeout_o(timeout_o)
  );

  assign rd_data_o = head.data;
  assign rd_perr_o = head.perr;
  assign rd_ferr_o = head.ferr;
  assign rd_brk_o  = head.brk;
  assign thresh_o  = (trig_lvl_i != '0) && (level_o >= trig_lvl_i);

  p_thresh_track_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thresh_o && !push && !rd_i && trig_lvl_i == $past(trig_lvl_i)) |=> thresh_o);
  p_empty_head_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push) |=> empty_o);
endmodule

// File: tb/sim_serial_rx_buf.sv
module sim_serial_rx_buf;
  localparam int BITC = 64;  // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] len_sel = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [6:0] trig = 7'd0;
  logic       rd = 1'b0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, empty, thresh, overrun, timeout;
  logic [6:0] level;

  int n_chk = 0, n_bad = 0, ovr_cnt = 0;
  bit mon_en = 1'b0;
  string cur_req = "R1";
  logic [10:0] exp_q[$];

  serial_rx_buf u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rxd_i(rxd),
    .len_sel_i(len_sel), .par_en_i(par_en), .par_odd_i(par_odd),
    .trig_lvl_i(trig), .rd_i(rd), .rd_data_o(rd_data), .rd_perr_o(rd_perr),
    .rd_ferr_o(rd_ferr), .rd_brk_o(rd_brk), .empty_o(empty), .level_o(level),
    .thresh_o(thresh), .overrun_o(overrun), .timeout_o(timeout)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (overrun) ovr_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare head entry, then pop it
  initial forever begin
    @(negedge clk);
    if (mon_en && !empty) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: actual %0h expected none", cur_req, {rd_data, rd_perr, rd_ferr, rd_brk});
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        if ({rd_data, rd_perr, rd_ferr, rd_brk} !== e) begin
          n_bad++;
          $display("FAIL %s: actual %0h expected %0h", cur_req,
                   {rd_data, rd_perr, rd_ferr, rd_brk}, e);
        end
      end
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
    end
  end

  task automatic bit_hold(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  // send one frame and queue its expected entry
  task automatic tx(input logic [7:0] d, input int nb, input bit pen, input bit odd,
                    input bit flip, input bit bad_stop, input bit expect_it);
    logic [7:0] m;
    m = 8'((1 << nb) - 1) & d;
    len_sel = 2'(nb - 5);
    par_en  = pen;
    par_odd = odd;
    if (expect_it) exp_q.push_back({m, pen & flip, bad_stop, 1'b0});
    bit_hold(1'b0, BITC);
    for (int i = 0; i < nb; i++) bit_hold(m[i], BITC);
    if (pen) bit_hold((^m) ^ odd ^ flip, BITC);
    if (bad_stop) bit_hold(1'b0, 48);
    else bit_hold(1'b1, BITC);
    bit_hold(1'b1, BITC);
  endtask

  task automatic drain;
    mon_en = 1'b1;
    for (int i = 0; i < 20000 && (exp_q.size() != 0 || !empty); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(cur_req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", empty, 1);
    chk("R1", level, 0);
    chk("R1", {thresh, overrun, timeout}, 0);

    // R2 / R7 8-bit frames in order
    cur_req = "R2";
    mon_en = 1'b1;
    tx(8'hA5, 8, 0, 0, 0, 0, 1);
    tx(8'h3C, 8, 0, 0, 0, 0, 1);
    tx(8'hFF, 8, 0, 0, 0, 0, 1);
    tx(8'h00, 8, 0, 0, 0, 0, 1);
    tx(8'hFF, 5, 0, 0, 0, 0, 1);   // R2 5-bit, upper bits zero
    tx(8'h2D, 6, 0, 0, 0, 0, 1);
    drain();

    // R3 parity modes and parity error
    cur_req = "R3";
    tx(8'h55, 7, 1, 0, 0, 0, 1);
    tx(8'h2A, 6, 1, 1, 0, 0, 1);
    tx(8'h81, 8, 1, 0, 1, 0, 1);
    tx(8'h13, 5, 1, 1, 1, 0, 1);
    drain();

    // R4 framing error
    cur_req = "R4";
    tx(8'h5A, 8, 0, 0, 0, 1, 1);
    tx(8'h66, 8, 0, 0, 0, 0, 1);
    drain();

    // R5 false start
    cur_req = "R5";
    bit_hold(1'b0, 16);
    bit_hold(1'b1, 2 * BITC);
    chk("R5", empty, 1);
    chk("R5", level, 0);

    // R6 break: one entry, none until high
    cur_req = "R6";
    len_sel = 2'd3; par_en = 1'b0;
    exp_q.push_back({8'h00, 1'b0, 1'b0, 1'b1});
    bit_hold(1'b0, 22 * BITC);
    bit_hold(1'b1, 4 * BITC);
    drain();
    chk("R6", level, 0);

    // R9 threshold
    cur_req = "R9";
    mon_en = 1'b0;
    trig = 7'd4;
    for (int i = 0; i < 3; i++) tx(8'(8'h10 + i), 8, 0, 0, 0, 0, 1);
    chk("R9", level, 3);
    chk("R9", thresh, 0);
    tx(8'h20, 8, 0, 0, 0, 0, 1);
    chk("R9", thresh, 1);
    drain();
    chk("R9", thresh, 0);
    trig = 7'd0;

    // R10 timeout
    cur_req = "R10";
    mon_en = 1'b0;
    tx(8'h77, 8, 0, 0, 0, 0, 1);
    repeat (1500) @(negedge clk);
    chk("R10", timeout, 0);
    repeat (1500) @(negedge clk);
    chk("R10", timeout, 1);
    drain();
    chk("R10", timeout, 0);

    // R8 overrun: 65th dropped, contents kept
    cur_req = "R8";
    mon_en = 1'b0;
    begin
      int base;
      base = ovr_cnt;
      for (int i = 0; i < 65; i++) tx(8'(i * 3 + 1), 8, 0, 0, 0, 0, i < 64);
      chk("R8", level, 64);
      chk("R8", ovr_cnt - base, 1);
    end
    cur_req = "R7";
    drain();
    chk("R7", empty, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule